// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst on a synchronous burst memory. A strobe captures a complete starting address. From then on, each clock cycle that has the advance input set moves the two low address bits one step through the burst order. The upper bits stay at the value that was loaded. The block drives the current address and a flag that is set on the fourth beat.

Two strobes can load the address: one for the processor and one for the controller. They have equal effect. A load always wins over an advance in the same cycle.

The burst order is picked by a mode input, which is sampled only while reset is held:
- **Linear order** counts the low bits upward and wraps modulo four.
- **Interleaved order** XORs the start bits with a beat count.

After four beats, a further advance returns to the starting address instead of moving into the next line.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block clears its state. After that edge, addr_out is 0 and last_beat is 0.
- R2: At a rising edge where strobe_p or strobe_c is 1, the whole of addr_in is loaded. After that edge, addr_out equals the loaded value and last_beat is 0.
- R3: When both strobes are 1 in the same cycle, the result is the same as with one strobe. A load takes precedence over adv=1 in the same cycle.
- R4: At an edge with no strobe and adv=0, addr_out and last_beat keep their values.
- R5: With the linear order (mode_ilv=0 at reset), each advance adds 1 modulo 4 to addr_out[1:0]. For example, a start of 1 gives 1, 2, 3, 0.
- R6: With the interleaved order (mode_ilv=1 at reset), addr_out[1:0] equals the start bits XOR k, where k counts advances modulo 4. For example, a start of 1 gives 1, 0, 3, 2.
- R7: addr_out[ADDR_W-1:2] changes only at a load edge.
- R8: last_beat is 1 exactly when three advances have happened since the last load (the fourth beat).
- R9: An advance from the fourth beat returns addr_out to the loaded starting address.
- R10: mode_ilv is sampled only at edges where rst_n is low. Changing it while rst_n is high has no effect on the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; mode_ilv is captured while it is low |
| mode_ilv | input | 1 | Burst order: 0 selects linear, 1 selects interleaved |
| strobe_p | input | 1 | Processor address strobe; loads addr_in |
| strobe_c | input | 1 | Controller address strobe; loads addr_in |
| adv | input | 1 | Advance to the next beat |
| addr_in | input | ADDR_W | Starting address |
| addr_out | output | ADDR_W | Address of the current beat |
| last_beat | output | 1 | Set on the fourth beat of the burst |

## Verification
The assertions check the following on every cycle:
- a load lands the captured address and clears last_beat;
- an idle cycle holds the outputs;
- the upper bits move only on a load;
- each advance makes the step the selected order allows;
- the order flag stays fixed outside reset.

Some behaviour can only be shown by the bench's scenarios against its reference model:
- the exact full sequence from every start value in both orders;
- the return to the start after the fourth beat;
- strobes that collide with each other or with an advance;
- a mode change outside reset that must not alter the order.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ilv,
  input  logic              strobe_p,
  input  logic              strobe_c,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              last_beat
);
  localparam int HI = ADDR_W - 1;

  logic [HI:0] base_q;
  logic [1:0]  beat_q;
  logic        ilv_q;
  logic [1:0]  low;
  logic        load;

  assign load = strobe_p | strobe_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      ilv_q  <= mode_ilv;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (adv) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign low       = ilv_q ? (base_q[1:0] ^ beat_q) : (base_q[1:0] + beat_q);
  assign addr_out  = {base_q[HI:2], low};
  assign last_beat = &beat_q;

  // R2
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load)) |-> (addr_out == $past(addr_in) && !last_beat));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load) && !$past(adv)) |-> ($stable(addr_out) && $stable(last_beat)));

  // R7
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load)) |-> $stable(addr_out[HI:2]));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load) && $past(adv) && !ilv_q)
      |-> (addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

  // R6
  ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load) && $past(adv) && ilv_q)
      |-> ((addr_out[0] ^ $past(addr_out[0])) == 1'b1));

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load) && $past(adv) && $past(last_beat)) |-> !last_beat);

  // R10
  mode_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(ilv_q));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int PERIOD = 10;
  localparam int AW = 20;

  logic clk = 0, rst_n = 0, mode_ilv = 0, strobe_p = 0, strobe_c = 0, adv = 0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic last_beat;

  int errors = 0, checks = 0;
  int m_base = 0, m_cnt = 0, m_mode = 0;

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .mode_ilv(mode_ilv), .strobe_p(strobe_p),
    .strobe_c(strobe_c), .adv(adv), .addr_in(addr_in),
    .addr_out(addr_out), .last_beat(last_beat));

  always #(PERIOD/2) clk = ~clk;

  function automatic int exp_addr();
    int lo;
    if (m_mode != 0) lo = (m_base & 3) ^ m_cnt;
    else lo = ((m_base & 3) + m_cnt) % 4;
    return (m_base & ~3) | lo;
  endfunction

  task automatic check(string tag);
    int ea;
    int el;
    ea = exp_addr();
    el = (m_cnt == 3) ? 1 : 0;
    checks++;
    if (int'(addr_out) != ea) begin
      errors++;
      $display("FAIL %s addr_out actual=%0h expected=%0h", tag, addr_out, ea);
    end
    checks++;
    if (int'(last_beat) != el) begin
      errors++;
      $display("FAIL %s last_beat actual=%0d expected=%0d", tag, last_beat, el);
    end
  endtask

  task automatic step(logic r, logic p, logic c, logic a, int ad, string tag);
    rst_n = r; strobe_p = p; strobe_c = c; adv = a; addr_in = AW'(ad);
    @(posedge clk);
    if (!r) begin
      m_mode = int'(mode_ilv); m_base = 0; m_cnt = 0;
    end else if (p || c) begin
      m_base = ad; m_cnt = 0;
    end else if (a) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic burst(int start, string tag);
    step(1, 1, 0, 0, start, tag);
    for (int k = 0; k < 5; k++) step(1, 0, 0, 1, 0, tag);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    mode_ilv = 0;
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, "R1");
    step(1, 1, 0, 0, 'h5A5A7, "R2");
    step(1, 0, 1, 0, 'h12340, "R2");
    step(1, 0, 0, 0, 'hFFFFF, "R4");
    step(1, 0, 0, 0, 0, "R4");
    for (int s = 0; s < 4; s++) burst('hABC00 + s, "R5");
    step(1, 1, 0, 0, 'h00013, "R9");
    for (int k = 0; k < 3; k++) step(1, 0, 0, 1, 0, "R8");
    step(1, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 1, 0, "R9");
    step(1, 1, 1, 1, 'h77772, "R3");
    step(1, 0, 0, 1, 0, "R7");
    step(1, 0, 1, 1, 'h0F0F1, "R3");
    step(1, 1, 0, 1, 'h0F0F3, "R3");
    mode_ilv = 1;
    for (int k = 0; k < 4; k++) step(1, 0, 0, 1, 'hFFFFF, "R10");
    burst('h22221, "R10");
    step(0, 0, 0, 0, 0, "R1");
    mode_ilv = 0;
    for (int s = 0; s < 4; s++) burst('h3C3C0 + s, "R6");
    step(1, 1, 0, 0, 'h00002, "R6");
    step(1, 0, 0, 1, 0, "R6");
    step(1, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 1, 0, "R7");
    step(1, 0, 0, 1, 0, "R8");
    step(1, 0, 0, 1, 0, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule